// File: doc/BRIEF.md
# DMA Bus Handover Sequencer

This block moves ownership of the system bus from the CPU to a DMA engine on the same card for one byte transfer, and then gives the bus back. A request from the engine raises a bus hold request. The sequencer then waits until the CPU finishes its current cycle and grants the hold. After the grant, the card's address and data drivers come up first. The card's DMA acknowledge, which takes over the status and control lines, comes up only after a programmed overlap. During that overlap both the card and the CPU drive those lines.

With the bus held, one transfer runs in the direction sampled at the grant. A memory-to-disk step raises the memory-read strobe first and adds the I/O-write strobe after a separation. A disk-to-memory step raises the I/O-read strobe first and adds the memory-write strobe after the same separation. Release follows the same stages in reverse. If the CPU withdraws its grant partway through, the sequencer unwinds in order from wherever it stands.

All delays are counts of clock cycles, each at least one: `OVERLAP_CYC` (driver/acknowledge overlap, used on both takeover and release), `SEP_CYC` (leading strobe alone, on both rising and falling side) and `PULSE_CYC` (both strobes high).

Top module: `bus_handover_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is low.
- R2: A high `dma_req` in the idle state raises `bus_hold_req` one cycle later. The hold stays high while `hold_ack` is low. If `dma_req` falls before any grant, `bus_hold_req` drops one cycle later.
- R3: A `hold_ack` seen while the hold is requested raises `addr_en` one cycle later. `bus_hold_req` stays high for as long as `addr_en` is high.
- R4: `dma_ack` rises exactly `OVERLAP_CYC` cycles after `addr_en` rises, so the two overlap before the status lines change hands.
- R5: Memory-to-disk (`to_disk`=1): `mem_rd_stb` rises together with `dma_ack`. `io_wr_stb` joins it `SEP_CYC` cycles later and stays high for `PULSE_CYC` cycles. `io_rd_stb` and `mem_wr_stb` stay low.
- R6: Disk-to-memory (`to_disk`=0): `io_rd_stb` rises together with `dma_ack`. `mem_wr_stb` joins it `SEP_CYC` cycles later and stays high for `PULSE_CYC` cycles. `mem_rd_stb` and `io_wr_stb` stay low.
- R7: Release runs in reverse order. The trailing strobe falls first. `SEP_CYC` cycles later, the leading strobe and `dma_ack` fall. `OVERLAP_CYC` cycles after that, `addr_en` falls. One cycle later, `bus_hold_req` falls.
- R8: `to_disk` is sampled only in the grant cycle. Changing it later in the sequence has no effect on the strobes.
- R9: If `hold_ack` falls while the bus is held, the release starts at once from the current stage. From the driver-only stage, `addr_en` falls next and then the hold. From the leading-strobe stage, the strobe and `dma_ack` fall next. From the both-strobes stage, the trailing strobe falls next. Each following step keeps its normal delay.
- R10: If a lost grant and the end of a stage's delay fall in the same cycle, the lost grant decides the next stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_req | input | 1 | Hold request from the DMA engine |
| to_disk | input | 1 | Transfer direction: 1 memory-to-disk, 0 disk-to-memory |
| hold_ack | input | 1 | Hold acknowledge from the CPU |
| bus_hold_req | output | 1 | Bus hold request to the CPU |
| addr_en | output | 1 | Card address/data drivers on, CPU address/data drivers off |
| dma_ack | output | 1 | Card status/control on, CPU status/control off |
| mem_rd_stb | output | 1 | Memory-read strobe |
| io_wr_stb | output | 1 | I/O-write strobe into the disk controller |
| io_rd_stb | output | 1 | I/O-read strobe from the disk controller |
| mem_wr_stb | output | 1 | Memory-write strobe |

## Verification
Two events can land in the same cycle: the CPU withdrawing its grant, and a stage reaching the end of its programmed delay. Both are provoked together by dropping `hold_ack` in the final cycle of the leading-strobe stage. The bench then expects the strobe and acknowledge to fall rather than the trailing strobe to rise. It also drops the grant in the first cycle of the both-strobes stage and in the driver-only stage, and compares every output, cycle by cycle, against the stage sequence that the requirements predict.

// File: rtl/bho_pkg.sv
package bho_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_REQ,
    PH_AEN,
    PH_LEAD,
    PH_BOTH,
    PH_TAIL,
    PH_UNACK,
    PH_RELS
  } phase_e;

  typedef struct packed {
    logic hold;
    logic aen;
    logic dack;
    logic mrd;
    logic iow;
    logic ird;
    logic mwr;
  } bus_ctl_t;

endpackage

// File: rtl/bho_dwell_timer.sv
module bho_dwell_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] len,
  output logic          expire
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign expire = (cnt_q == (len - ONE));
  assign cnt_en = restart | ~expire;

  always_comb begin
    if (restart) cnt_d = '0;
    else         cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/bho_phase_fsm.sv
module bho_phase_fsm
  import bho_pkg::*;
#(
  parameter int CW          = 2,
  parameter int OVERLAP_CYC = 2,
  parameter int SEP_CYC     = 2,
  parameter int PULSE_CYC   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_req,
  input  logic          hold_ack,
  input  logic          to_disk,
  input  logic          expire,
  output logic          restart,
  output logic [CW-1:0] len,
  output phase_e        phase_q,
  output logic          dir_q
);

  phase_e phase_d;
  logic   dir_en;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (dma_req) phase_d = PH_REQ;
      PH_REQ: begin
        if (hold_ack)     phase_d = PH_AEN;
        else if (!dma_req) phase_d = PH_IDLE;
      end
      PH_AEN: begin
        if (!hold_ack)   phase_d = PH_RELS;
        else if (expire) phase_d = PH_LEAD;
      end
      PH_LEAD: begin
        if (!hold_ack)   phase_d = PH_UNACK;
        else if (expire) phase_d = PH_BOTH;
      end
      PH_BOTH:  if (!hold_ack || expire) phase_d = PH_TAIL;
      PH_TAIL:  if (expire) phase_d = PH_UNACK;
      PH_UNACK: if (expire) phase_d = PH_RELS;
      PH_RELS:  phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    unique case (phase_q)
      PH_AEN, PH_UNACK: len = CW'(OVERLAP_CYC);
      PH_LEAD, PH_TAIL: len = CW'(SEP_CYC);
      PH_BOTH:          len = CW'(PULSE_CYC);
      default:          len = CW'(1);
    endcase
  end

  assign restart = (phase_d != phase_q);
  assign dir_en  = (phase_q == PH_REQ) & hold_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= 1'b0;
    else if (dir_en) dir_q <= to_disk;
  end

endmodule

// File: rtl/bho_ctl_decode.sv
module bho_ctl_decode
  import bho_pkg::*;
(
  input  phase_e   phase,
  input  logic     dir,
  output bus_ctl_t ctl
);

  logic drv_stage;
  logic lead_on;
  logic trail_on;

  always_comb begin
    drv_stage = 1'b0;
    lead_on   = 1'b0;
    trail_on  = 1'b0;
    unique case (phase)
      PH_AEN, PH_UNACK: drv_stage = 1'b1;
      PH_LEAD, PH_TAIL: begin
        drv_stage = 1'b1;
        lead_on   = 1'b1;
      end
      PH_BOTH: begin
        drv_stage = 1'b1;
        lead_on   = 1'b1;
        trail_on  = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    ctl.hold = (phase != PH_IDLE);
    ctl.aen  = drv_stage;
    ctl.dack = lead_on;
    ctl.mrd  = lead_on  &  dir;
    ctl.iow  = trail_on &  dir;
    ctl.ird  = lead_on  & ~dir;
    ctl.mwr  = trail_on & ~dir;
  end

endmodule

// File: rtl/bus_handover_seq.sv
module bus_handover_seq
  import bho_pkg::*;
#(
  parameter int OVERLAP_CYC = 2,
  parameter int SEP_CYC     = 2,
  parameter int PULSE_CYC   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_req,
  input  logic to_disk,
  input  logic hold_ack,
  output logic bus_hold_req,
  output logic addr_en,
  output logic dma_ack,
  output logic mem_rd_stb,
  output logic io_wr_stb,
  output logic io_rd_stb,
  output logic mem_wr_stb
);

  localparam int MAX_AB = (OVERLAP_CYC > SEP_CYC) ? OVERLAP_CYC : SEP_CYC;
  localparam int MAXD   = (MAX_AB > PULSE_CYC) ? MAX_AB : PULSE_CYC;
  localparam int CW     = $clog2(MAXD + 1);

  logic          restart;
  logic          expire;
  logic [CW-1:0] len;
  phase_e        phase_q;
  logic          dir_q;
  bus_ctl_t      ctl;

  bho_phase_fsm #(
    .CW          (CW),
    .OVERLAP_CYC (OVERLAP_CYC),
    .SEP_CYC     (SEP_CYC),
    .PULSE_CYC   (PULSE_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .dma_req  (dma_req),
    .hold_ack (hold_ack),
    .to_disk  (to_disk),
    .expire   (expire),
    .restart  (restart),
    .len      (len),
    .phase_q  (phase_q),
    .dir_q    (dir_q)
  );

  bho_dwell_timer #(
    .CW (CW)
  ) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .len     (len),
    .expire  (expire)
  );

  bho_ctl_decode u_dec (
    .phase (phase_q),
    .dir   (dir_q),
    .ctl   (ctl)
  );

  assign bus_hold_req = ctl.hold;
  assign addr_en      = ctl.aen;
  assign dma_ack      = ctl.dack;
  assign mem_rd_stb   = ctl.mrd;
  assign io_wr_stb    = ctl.iow;
  assign io_rd_stb    = ctl.ird;
  assign mem_wr_stb   = ctl.mwr;

endmodule

// File: rtl/bho_sva.sv
module bho_sva #(
  parameter int OVERLAP_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic hold_ack,
  input logic bus_hold_req,
  input logic addr_en,
  input logic dma_ack,
  input logic mem_rd_stb,
  input logic io_wr_stb,
  input logic io_rd_stb,
  input logic mem_wr_stb
);

  localparam int OCW = $clog2(OVERLAP_CYC + 2);

  logic [OCW-1:0] ovl_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ovl_cnt <= '0;
    else if (!addr_en)          ovl_cnt <= '0;
    else if (!dma_ack && ovl_cnt != {OCW{1'b1}}) ovl_cnt <= ovl_cnt + OCW'(1);
  end

  assert_rst_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !(bus_hold_req | addr_en | dma_ack));

  assert_hold_after_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_en) |-> $past(hold_ack) && $past(bus_hold_req));

  assert_hold_covers_drivers_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_en |-> bus_hold_req);

  assert_overlap_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_ack) |-> $past(addr_en) && (ovl_cnt == OCW'(OVERLAP_CYC)));

  assert_write_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_wr_stb) |-> $past(mem_rd_stb));

  assert_read_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_stb) |-> $past(io_rd_stb));

  assert_strobe_needs_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_stb | io_wr_stb | io_rd_stb | mem_wr_stb) |-> dma_ack);

  assert_one_direction_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !((mem_rd_stb | io_wr_stb) & (io_rd_stb | mem_wr_stb)));

  assert_strobe_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_rd_stb, io_wr_stb, io_rd_stb, mem_wr_stb}) <= 2);

  assert_aen_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addr_en) |-> $past(!dma_ack));

  assert_hold_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_hold_req) |-> $past(!addr_en));

  assert_trail_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_ack) |-> !(io_wr_stb | mem_wr_stb) && $past(!(io_wr_stb | mem_wr_stb)));

endmodule

bind bus_handover_seq bho_sva #(
  .OVERLAP_CYC (OVERLAP_CYC)
) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .hold_ack     (hold_ack),
  .bus_hold_req (bus_hold_req),
  .addr_en      (addr_en),
  .dma_ack      (dma_ack),
  .mem_rd_stb   (mem_rd_stb),
  .io_wr_stb    (io_wr_stb),
  .io_rd_stb    (io_rd_stb),
  .mem_wr_stb   (mem_wr_stb)
);

// File: tb/sim_bus_handover_seq.sv
`timescale 1ns/1ps
module sim_bus_handover_seq;

  localparam int O = 2;
  localparam int S = 2;
  localparam int P = 3;

  // vector order: {hold, aen, dack, mrd, iow, ird, mwr}
  localparam logic [6:0] V_IDLE  = 7'b0000000;
  localparam logic [6:0] V_REQ   = 7'b1000000;
  localparam logic [6:0] V_AEN   = 7'b1100000;
  localparam logic [6:0] V_WLEAD = 7'b1111000;
  localparam logic [6:0] V_WBOTH = 7'b1111100;
  localparam logic [6:0] V_RLEAD = 7'b1110010;
  localparam logic [6:0] V_RBOTH = 7'b1110011;

  logic clk = 1'b0;
  logic rst_n;
  logic dma_req, to_disk, hold_ack;
  logic bus_hold_req, addr_en, dma_ack;
  logic mem_rd_stb, io_wr_stb, io_rd_stb, mem_wr_stb;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  bus_handover_seq #(
    .OVERLAP_CYC (O),
    .SEP_CYC     (S),
    .PULSE_CYC   (P)
  ) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .dma_req      (dma_req),
    .to_disk      (to_disk),
    .hold_ack     (hold_ack),
    .bus_hold_req (bus_hold_req),
    .addr_en      (addr_en),
    .dma_ack      (dma_ack),
    .mem_rd_stb   (mem_rd_stb),
    .io_wr_stb    (io_wr_stb),
    .io_rd_stb    (io_rd_stb),
    .mem_wr_stb   (mem_wr_stb)
  );

  function automatic logic [6:0] outs();
    return {bus_hold_req, addr_en, dma_ack, mem_rd_stb, io_wr_stb, io_rd_stb, mem_wr_stb};
  endfunction

  task automatic check_now(input logic [6:0] exp, input string req);
    checks++;
    if (outs() !== exp) begin
      fails++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, outs(), exp);
    end
  endtask

  task automatic expect_n(input logic [6:0] exp, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_now(exp, req);
    end
  endtask

  // idle -> request pending for two extra cycles -> grant given; ends at a negedge
  task automatic open_req(input logic dir);
    @(negedge clk);
    dma_req = 1'b1;
    to_disk = dir;
    expect_n(V_REQ, 3, "R2");
    hold_ack = 1'b1;
    dma_req  = 1'b0;
  endtask

  task automatic finish_idle();
    hold_ack = 1'b0;
    expect_n(V_IDLE, 2, "R7");
  endtask

  task automatic t_reset();
    rst_n = 1'b0; dma_req = 1'b0; to_disk = 1'b0; hold_ack = 1'b0;
    repeat (3) @(negedge clk);
    check_now(V_IDLE, "R1");
    rst_n = 1'b1;
    expect_n(V_IDLE, 1, "R1");
  endtask

  task automatic t_withdraw();
    @(negedge clk);
    dma_req = 1'b1;
    expect_n(V_REQ, 2, "R2");
    dma_req = 1'b0;
    expect_n(V_IDLE, 2, "R2");
  endtask

  // full transfer; flip toggles to_disk after the grant (R8)
  task automatic t_full(input logic dir, input logic flip);
    logic [6:0] lead, both;
    lead = dir ? V_WLEAD : V_RLEAD;
    both = dir ? V_WBOTH : V_RBOTH;
    open_req(dir);
    expect_n(V_AEN, 1, "R3");
    if (flip) to_disk = ~dir;
    expect_n(V_AEN, O - 1, "R4");
    expect_n(lead, S, dir ? "R5" : "R6");
    expect_n(both, P, flip ? "R8" : (dir ? "R5" : "R6"));
    expect_n(lead, S, "R7");
    expect_n(V_AEN, O, "R7");
    expect_n(V_REQ, 1, "R7");
    finish_idle();
  endtask

  task automatic t_abort_aen();
    open_req(1'b1);
    expect_n(V_AEN, 1, "R9");
    hold_ack = 1'b0;
    expect_n(V_REQ, 1, "R9");
    expect_n(V_IDLE, 2, "R9");
  endtask

  task automatic t_abort_lead_last();
    open_req(1'b0);
    expect_n(V_AEN, O, "R4");
    expect_n(V_RLEAD, S, "R6");
    hold_ack = 1'b0;  // same cycle as end of leading stage
    expect_n(V_AEN, O, "R10");
    expect_n(V_REQ, 1, "R10");
    expect_n(V_IDLE, 2, "R10");
  endtask

  task automatic t_abort_both();
    open_req(1'b1);
    expect_n(V_AEN, O, "R4");
    expect_n(V_WLEAD, S, "R5");
    expect_n(V_WBOTH, 1, "R5");
    hold_ack = 1'b0;
    expect_n(V_WLEAD, S, "R9");
    expect_n(V_AEN, O, "R9");
    expect_n(V_REQ, 1, "R9");
    expect_n(V_IDLE, 2, "R9");
  endtask

  initial begin
    t_reset();
    t_withdraw();
    t_full(1'b1, 1'b0);
    t_full(1'b0, 1'b0);
    t_full(1'b1, 1'b1);
    t_full(1'b0, 1'b1);
    t_abort_aen();
    t_abort_lead_last();
    t_abort_both();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: run did not end, got hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule